// File: doc/BRIEF.md
# Race Start-Light Sequencer

This controller runs a motor-race start-light sequence and then measures how quickly a player reacts. A press of an active-low start key begins the sequence: a row of ten LEDs fills from the leftmost position towards the right, one LED per half-second tick, until every LED is lit. The controller then fires a one-cycle trigger at an external random-delay timer and waits for that timer's timeout. When the timeout arrives, every LED goes dark at once and the controller begins counting millisecond ticks. It stops counting when the player presses a second active-low key.

The two tick inputs come from external dividers. Each is a single system-clock pulse, 20 ns wide at 50 MHz. Both key inputs pass through a two-flop synchroniser, and the controller acts only on the falling edge of each key. The timer enable output lets the random source in the delay timer run while the controller is idle or showing a result. The start press freezes it. If the reaction key is pressed before the lights go out, the result is a false start: the reaction count jumps to its maximum value and no counting takes place. The result is held until the next start press.

Top module: `race_start_seq`

## Requirements
- R1: While reset is high, and after it is released, the LED vector is all zeros, the reaction count is zero, the delay trigger is low and the delay enable is high.
- R2: A start-key falling edge seen while idle or showing a result begins a fill. The edge acts two clock edges after the key is first sampled low. After that, each half-second tick lights the next LED, from bit 9 (leftmost) down to bit 0, until all ten bits are 1.
- R3: The delay trigger pulses high for exactly one clock cycle per sequence, in the first cycle in which all ten LEDs are lit. The controller then holds and waits for the timeout.
- R4: A timeout received while holding clears all ten LEDs at the same clock edge. A timeout received while the LEDs are still filling is ignored.
- R5: The delay enable is high while idle or showing a result, and low from the start press until the result is captured.
- R6: After the LEDs go off, the reaction count rises by one on each millisecond tick. On a reaction-key falling edge it stops, and it keeps its value until the next start press.
- R7: The reaction count is 17 bits wide and stays at 131071 instead of wrapping.
- R8: A reaction-key falling edge during the fill or the hold marks a false start. At the timeout the LEDs go off, the count becomes 131071 at once, and no ticks are counted.
- R9: Start-key presses during the fill, the hold or reaction timing are ignored.
- R10: A start press while a result is shown clears the count to zero and begins a new fill.
- R11: A millisecond tick that arrives in the same cycle as the reaction-key edge acts on is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tickMs | input | 1 | One-cycle pulse every millisecond |
| tickHalf | input | 1 | One-cycle pulse every half second |
| startKeyN | input | 1 | Start key, active low, debounced |
| reactKeyN | input | 1 | Reaction key, active low, debounced |
| delayTimeout | input | 1 | Timeout pulse from the random-delay timer |
| leds | output | 10 | Light row, bit 9 leftmost |
| delayTrigger | output | 1 | One-cycle start pulse to the delay timer |
| delayEnable | output | 1 | Run enable for the delay timer's random source |
| reactCount | output | 17 | Reaction time in milliseconds, saturating |

## Verification
The bench targets the points where the phases change hands. These include a timeout that arrives while the LEDs are still filling, which a faulty design would take to blank the lights early. They also include a start press in mid-sequence, which a faulty design would use to restart the fill. A reaction press before lights-out must yield the saturated count and not a small number. The bench runs the counter to saturation, where a wrapping design would drop to zero. It also presses the reaction key on a cycle that carries a millisecond tick, where a design that counts the tick first is off by one. A cycle-accurate model in the bench is compared against every output on every clock, so a trigger lasting two cycles or an LED lit one tick late is reported.

// File: rtl/race_start_pkg.sv
package race_start_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FILL,
    PH_HOLD,
    PH_WAIT,
    PH_DONE
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic shiftLed;
    logic ledsOff;
    logic countEn;
    logic forceMax;
  } pathCtrl_t;

endpackage

// File: rtl/race_key_edge.sv
module race_key_edge (
  input  logic clk,
  input  logic rst,
  input  logic keyN,
  output logic pressEdge
);

  logic syncA, syncB, lastB;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
      lastB <= 1'b1;
    end else begin
      syncA <= keyN;
      syncB <= syncA;
      lastB <= syncB;
    end
  end

  assign pressEdge = lastB & ~syncB;

endmodule

// File: rtl/race_start_fsm.sv
module race_start_fsm
  import race_start_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      startPress,
  input  logic      reactPress,
  input  logic      tickHalf,
  input  logic      delayTimeout,
  input  logic      ledsFull,
  output pathCtrl_t ctrl,
  output logic      delayTrigger,
  output logic      delayEnable
);

  phase_t phase, phaseNext;
  logic   jumped, jumpedNext;

  always_comb begin
    phaseNext  = phase;
    jumpedNext = jumped;
    ctrl       = '0;
    unique case (phase)
      PH_IDLE, PH_DONE: begin
        if (startPress) begin
          phaseNext     = PH_FILL;
          ctrl.clearAll = 1'b1;
          jumpedNext    = 1'b0;
        end
      end
      PH_FILL: begin
        if (reactPress) jumpedNext = 1'b1;
        if (ledsFull) phaseNext = PH_HOLD;
        else          ctrl.shiftLed = tickHalf;
      end
      PH_HOLD: begin
        if (reactPress) jumpedNext = 1'b1;
        if (delayTimeout) begin
          ctrl.ledsOff = 1'b1;
          if (jumped || reactPress) begin
            ctrl.forceMax = 1'b1;
            phaseNext     = PH_DONE;
          end else begin
            phaseNext = PH_WAIT;
          end
        end
      end
      PH_WAIT: begin
        if (reactPress) phaseNext = PH_DONE;
        else            ctrl.countEn = 1'b1;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      jumped <= 1'b0;
    end else begin
      phase  <= phaseNext;
      jumped <= jumpedNext;
    end
  end

  assign delayTrigger = (phase == PH_FILL) && ledsFull;
  assign delayEnable  = (phase == PH_IDLE) || (phase == PH_DONE);

endmodule

// File: rtl/race_start_path.sv
module race_start_path
  import race_start_pkg::*;
#(
  parameter int NUM_LEDS = 10,
  parameter int COUNT_W  = 17
) (
  input  logic                clk,
  input  logic                rst,
  input  pathCtrl_t           ctrl,
  input  logic                tickMs,
  output logic [NUM_LEDS-1:0] leds,
  output logic                ledsFull,
  output logic [COUNT_W-1:0]  reactCount
);

  localparam logic [COUNT_W-1:0] COUNT_MAX = '1;

  logic atMax;
  assign atMax = (reactCount == COUNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || ctrl.clearAll || ctrl.ledsOff) begin
      leds <= '0;
    end else if (ctrl.shiftLed) begin
      leds <= {1'b1, leds[NUM_LEDS-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctrl.clearAll) begin
      reactCount <= '0;
    end else if (ctrl.forceMax) begin
      reactCount <= COUNT_MAX;
    end else if (ctrl.countEn && tickMs && !atMax) begin
      reactCount <= reactCount + 1'b1;
    end
  end

  assign ledsFull = leds[0];

endmodule

// File: rtl/race_start_seq.sv
module race_start_seq
  import race_start_pkg::*;
#(
  parameter int NUM_LEDS = 10,
  parameter int COUNT_W  = 17
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tickMs,
  input  logic                tickHalf,
  input  logic                startKeyN,
  input  logic                reactKeyN,
  input  logic                delayTimeout,
  output logic [NUM_LEDS-1:0] leds,
  output logic                delayTrigger,
  output logic                delayEnable,
  output logic [COUNT_W-1:0]  reactCount
);

  logic      startPress, reactPress, ledsFull;
  pathCtrl_t ctrl;

  race_key_edge startEdge_i (
    .clk(clk), .rst(rst), .keyN(startKeyN), .pressEdge(startPress)
  );

  race_key_edge reactEdge_i (
    .clk(clk), .rst(rst), .keyN(reactKeyN), .pressEdge(reactPress)
  );

  race_start_fsm fsm_i (
    .clk(clk), .rst(rst), .startPress(startPress), .reactPress(reactPress),
    .tickHalf(tickHalf), .delayTimeout(delayTimeout), .ledsFull(ledsFull),
    .ctrl(ctrl), .delayTrigger(delayTrigger), .delayEnable(delayEnable)
  );

  race_start_path #(.NUM_LEDS(NUM_LEDS), .COUNT_W(COUNT_W)) path_i (
    .clk(clk), .rst(rst), .ctrl(ctrl), .tickMs(tickMs),
    .leds(leds), .ledsFull(ledsFull), .reactCount(reactCount)
  );

endmodule

// File: rtl/race_start_seq_chk.sv
module race_start_seq_chk #(
  parameter int NUM_LEDS = 10,
  parameter int COUNT_W  = 17
) (
  input logic                clk,
  input logic                rst,
  input logic                delayTimeout,
  input logic [NUM_LEDS-1:0] leds,
  input logic                delayTrigger,
  input logic                delayEnable,
  input logic [COUNT_W-1:0]  reactCount
);

  localparam logic [NUM_LEDS-1:0] ALL_ON    = '1;
  localparam logic [COUNT_W-1:0]  COUNT_MAX = '1;

  logic [NUM_LEDS-1:0] darkBits, darkNext;
  assign darkBits = ~leds;
  assign darkNext = darkBits + 1'b1;

  // R2: lit LEDs always form a run starting at the left end
  assert_fill_shape_R2: assert property (@(posedge clk) disable iff (rst)
    ((darkBits & darkNext) == '0));

  // R3: trigger is a single-cycle pulse
  assert_trigger_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    delayTrigger |=> !delayTrigger);

  // R3: trigger only with all LEDs on
  assert_trigger_full_R3: assert property (@(posedge clk) disable iff (rst)
    delayTrigger |-> (leds == ALL_ON));

  // R4: timeout while holding blanks the row
  assert_timeout_off_R4: assert property (@(posedge clk) disable iff (rst)
    (delayTimeout && !delayEnable && !delayTrigger && leds == ALL_ON) |=> (leds == '0));

  // R5: enable only while the row is dark
  assert_enable_dark_R5: assert property (@(posedge clk) disable iff (rst)
    delayEnable |-> (leds == '0));

  // R6: count moves only by one step, a clear or a jump to the maximum
  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(reactCount) |-> (reactCount == COUNT_W'($past(reactCount) + 1'b1)
                              || reactCount == '0 || reactCount == COUNT_MAX));

  // R7: saturated count never wraps to a small nonzero value
  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (reactCount == COUNT_MAX) |=> (reactCount == COUNT_MAX || reactCount == '0));

endmodule

bind race_start_seq race_start_seq_chk #(.NUM_LEDS(NUM_LEDS), .COUNT_W(COUNT_W)) chk_i (
  .clk(clk), .rst(rst), .delayTimeout(delayTimeout), .leds(leds),
  .delayTrigger(delayTrigger), .delayEnable(delayEnable), .reactCount(reactCount)
);

// File: tb/race_start_seq_tb_top.sv
`timescale 1ns/1ps
module race_start_seq_tb_top;

  localparam int MAXC = 131071;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickMs = 1'b0, tickHalf = 1'b0;
  logic startKeyN = 1'b1, reactKeyN = 1'b1, delayTimeout = 1'b0;
  logic [9:0]  leds;
  logic        delayTrigger, delayEnable;
  logic [16:0] reactCount;

  always #10 clk = ~clk;

  race_start_seq dut_i (
    .clk(clk), .rst(rst), .tickMs(tickMs), .tickHalf(tickHalf),
    .startKeyN(startKeyN), .reactKeyN(reactKeyN), .delayTimeout(delayTimeout),
    .leds(leds), .delayTrigger(delayTrigger), .delayEnable(delayEnable),
    .reactCount(reactCount)
  );

  int checks = 0, errors = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phases: 0 idle, 1 fill, 2 hold, 3 timing, 4 result
  int mPhase = 0, mLit = 0, mCnt = 0;
  bit mJump = 0;
  bit sHist[$] = '{1, 1, 1};   // oldest sample at index 0
  bit rHist[$] = '{1, 1, 1};

  function automatic int litToVec(input int n);
    int v = 0;
    for (int i = 0; i < n; i++) v |= (1 << (9 - i));
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mPhase = 0; mLit = 0; mCnt = 0; mJump = 0;
      sHist = '{1, 1, 1}; rHist = '{1, 1, 1};
    end else begin
      bit sP, rP;
      sP = sHist[0] && !sHist[1];
      rP = rHist[0] && !rHist[1];
      case (mPhase)
        0, 4: if (sP) begin mPhase = 1; mLit = 0; mCnt = 0; mJump = 0; end
        1: begin
          if (rP) mJump = 1;
          if (mLit == 10) mPhase = 2;
          else if (tickHalf) mLit++;
        end
        2: begin
          if (rP) mJump = 1;
          if (delayTimeout) begin
            mLit = 0;
            if (mJump) begin mCnt = MAXC; mPhase = 4; end
            else mPhase = 3;
          end
        end
        3: begin
          if (rP) mPhase = 4;
          else if (tickMs && mCnt < MAXC) mCnt++;
        end
        default: ;
      endcase
      void'(sHist.pop_front()); sHist.push_back(startKeyN);
      void'(rHist.pop_front()); rHist.push_back(reactKeyN);
    end
  end

  int trigSeen = 0;
  always @(negedge clk) begin
    if (!rst) begin
      check("R2 leds", int'(leds), litToVec(mLit));
      check("R3 trigger", int'(delayTrigger), int'(mPhase == 1 && mLit == 10));
      check("R5 enable", int'(delayEnable), int'(mPhase == 0 || mPhase == 4));
      check("R6 count", int'(reactCount), mCnt);
      if (delayTrigger) trigSeen++;
    end
  end

  // ---------------- tick generators ----------------
  int halfPer = 4, msPer = 3, halfCnt = 0, msCnt = 0;
  always @(negedge clk) begin
    halfCnt = (halfCnt + 1) % halfPer;
    msCnt   = (msCnt + 1) % msPer;
    tickHalf <= (halfCnt == 0);
    tickMs   <= (msCnt == 0);
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pressStart();
    @(negedge clk); startKeyN <= 1'b0;
    waitCyc(4);     startKeyN <= 1'b1;
  endtask

  task automatic pressReact();
    @(negedge clk); reactKeyN <= 1'b0;
    waitCyc(4);     reactKeyN <= 1'b1;
  endtask

  task automatic pulseTimeout();
    @(negedge clk); delayTimeout <= 1'b1;
    @(negedge clk); delayTimeout <= 1'b0;
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int held;
    waitCyc(3);
    check("R1 leds in reset", int'(leds), 0);
    check("R1 enable in reset", int'(delayEnable), 1);
    @(negedge clk); rst <= 1'b0;
    waitCyc(2);
    check("R1 count after reset", int'(reactCount), 0);
    check("R1 trigger after reset", int'(delayTrigger), 0);

    // normal run with a mid-fill timeout and mid-fill start press
    pressStart();
    waitCyc(6);
    pulseTimeout();                          // R4: ignored during fill
    check("R4 early timeout ignored", int'(leds != 0), 1);
    pressStart();                            // R9: ignored
    waitCyc(50);
    check("R2 all lit", int'(leds), 10'h3FF);
    check("R3 single trigger", trigSeen, 1);
    pressStart();                            // R9: ignored in hold
    waitCyc(6);
    check("R9 hold keeps lights", int'(leds), 10'h3FF);
    pulseTimeout();
    waitCyc(40);
    check("R4 lights out", int'(leds), 0);
    check("R5 enable low while timing", int'(delayEnable), 0);
    pressStart();                            // R9: ignored while timing
    waitCyc(6);
    check("R9 timing continues", int'(delayEnable), 0);
    pressReact();
    waitCyc(4);
    held = int'(reactCount);
    check("R6 counted some ticks", int'(held > 0), 1);
    waitCyc(30);
    check("R6 result held", int'(reactCount), held);
    check("R5 enable in result", int'(delayEnable), 1);

    // R10 and R8: restart then false start during fill
    pressStart();
    check("R10 count cleared", int'(reactCount), 0);
    pressReact();
    waitCyc(50);
    pulseTimeout();
    waitCyc(3);
    check("R8 false start max", int'(reactCount), MAXC);
    check("R8 lights off", int'(leds), 0);
    check("R3 one trigger per run", trigSeen, 2);

    // R7: saturation with a tick every cycle
    msPer = 1;
    pressStart();
    waitCyc(50);
    pulseTimeout();
    waitCyc(131100);
    check("R7 saturated", int'(reactCount), MAXC);
    pressReact();
    waitCyc(4);
    check("R7 held at max", int'(reactCount), MAXC);

    // R11: press lands on a tick cycle (ticks every cycle)
    pressStart();
    waitCyc(50);
    pulseTimeout();
    waitCyc(20);
    pressReact();
    waitCyc(6);
    check("R11 tick on press not counted", int'(reactCount), mCnt);
    held = int'(reactCount);
    waitCyc(5);
    check("R11 frozen", int'(reactCount), held);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule